// File: doc/BRIEF.md
# Packed Calendar Clock Counter

This block keeps wall-clock time and date as one 32-bit packed word: seconds, minutes, hours, a 1-based day of week, day of month and a 1-based month. A separate 16-bit word holds the year as four BCD digits, with the century in the upper byte. A one-cycle pulse on the second tick input advances the calendar by one second. The advance handles each field's rollover, month lengths, Gregorian leap years and a decimal carry into the century.

Software sets the clock with two writes. The year write is held in a staging register. The following time write commits the staged year and the new time word in one cycle, so a reader never sees a half-updated date. The alarm match words use the same two-step scheme. A sticky alarm flag rises when both the running time word and the running year word equal the match words. It stays high until software clears it.

Top module: `calword_top`

## Requirements
- R1: After reset the time word reads 0x021E0000 (00:00:00, weekday 7 = Saturday, day 1, month 1), the year word reads 0x2000 and the alarm flag is 0.
- R2: The time word packs seconds in bits 5:0 (0–59), minutes in bits 11:6 (0–59), hours in bits 16:12 (0–23), weekday in bits 19:17 (1–7, 1 = Sunday), day of month in bits 24:20 (1–31) and month in bits 28:25 (1–12, 1 = January). Bits 31:29 always read 0, whatever value is loaded.
- R3: With no tick and no time write, the time and year words keep their values.
- R4: On a tick, seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0, each carrying into the next field.
- R5: At the midnight rollover the weekday advances by one, and 7 wraps to 1.
- R6: The day of month wraps to 1 after the last day of its month: 30 for months 4, 6, 9 and 11. February ends on day 29 in a leap year and on day 28 otherwise. A year is a leap year when it divides by 4, except century years that do not divide by 400. All other months end on day 31.
- R7: On the rollover past 31 December the month becomes 1 and the BCD year increments with a decimal carry into the century byte (for example 0x1999 to 0x2000 and 0x2099 to 0x2100).
- R8: A year write changes no visible output. A time write makes both the written time and the last staged year visible one cycle later. A time write wins over a tick in the same cycle.
- R9: A match year write is staged, and a match time write commits both match words. The alarm flag goes to 1 one cycle after the running time and year first equal the match words. It then stays 1 until a clear, and reads 0 in the cycle after the clear, even while the words are still equal.
- R10: The alarm does not fire when the time word matches but the year word differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse that advances the calendar by one second |
| wr_data | input | 32 | Write data for all load strobes |
| year_we | input | 1 | Stage wr_data[15:0] as the next year |
| time_we | input | 1 | Commit wr_data as the time word, together with the staged year |
| match_year_we | input | 1 | Stage wr_data[15:0] as the match year |
| match_time_we | input | 1 | Commit wr_data as the match time, together with the staged match year |
| alarm_clr | input | 1 | Clear the alarm flag |
| now_time | output | 32 | Running packed time word |
| now_year | output | 16 | Running BCD year |
| alarm | output | 1 | Sticky alarm flag |

## Verification
A tick or a time write that is sampled at one rising edge shows in now_time and now_year right after that edge, so the bench checks both words one cycle after the stimulus. The alarm flag sits one register further down, so the bench checks it twice. It must still read 0 in the cycle where the counter first equals the match words, and it must read 1 one cycle after that. Each stimulus is driven shortly after a rising edge, and results are read at that same point in the following cycle. This keeps every comparison clear of the edge.

// File: rtl/calword_pkg.sv
package calword_pkg;

    localparam int TIME_W = 32;
    localparam int YEAR_W = 16;
    localparam int YEAR_DIGITS = YEAR_W / 4;

    typedef struct packed {
        logic [2:0] pad;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    localparam cal_time_t TIME_AT_RESET = '{pad: 3'd0, mon: 4'd1, mday: 5'd1,
                                           wday: 3'd7, hour: 5'd0, min: 6'd0, sec: 6'd0};
    localparam logic [YEAR_W-1:0] YEAR_AT_RESET = 16'h2000;

    // two BCD digits divisible by 4: (10t + o) mod 4 == (2t + o) mod 4
    function automatic logic pair_div4(input logic [7:0] pair);
        logic [4:0] s;
        s = {pair[7:4], 1'b0} + {1'b0, pair[3:0]};
        return s[1:0] == 2'b00;
    endfunction

    function automatic logic is_leap_bcd(input logic [YEAR_W-1:0] y);
        if (y[7:0] == 8'h00)
            return pair_div4(y[15:8]);
        return pair_div4(y[7:0]);
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
        case (mon)
            4'd2:                    return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                 return 5'd31;
        endcase
    endfunction

    function automatic logic [YEAR_W-1:0] bcd_year_next(input logic [YEAR_W-1:0] y);
        logic [YEAR_W-1:0] r;
        logic carry;
        r = y;
        carry = 1'b1;
        for (int d = 0; d < YEAR_DIGITS; d++) begin
            if (carry) begin
                if (y[d*4 +: 4] >= 4'd9) begin
                    r[d*4 +: 4] = 4'd0;
                end else begin
                    r[d*4 +: 4] = y[d*4 +: 4] + 4'd1;
                    carry = 1'b0;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/calword_step.sv
module calword_step
    import calword_pkg::*;
(
    input  cal_time_t         cur,
    input  logic [YEAR_W-1:0] cur_year,
    output cal_time_t         nxt,
    output logic [YEAR_W-1:0] nxt_year
);
    logic       leap;
    logic [4:0] last_day;

    always_comb begin
        leap     = is_leap_bcd(cur_year);
        last_day = month_days(cur.mon, leap);
        nxt      = cur;
        nxt.pad  = '0;
        nxt_year = cur_year;
        if (cur.sec >= 6'd59) begin
            nxt.sec = '0;
            if (cur.min >= 6'd59) begin
                nxt.min = '0;
                if (cur.hour >= 5'd23) begin
                    nxt.hour = '0;
                    nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
                    if (cur.mday >= last_day) begin
                        nxt.mday = 5'd1;
                        if (cur.mon >= 4'd12) begin
                            nxt.mon  = 4'd1;
                            nxt_year = bcd_year_next(cur_year);
                        end else begin
                            nxt.mon = cur.mon + 4'd1;
                        end
                    end else begin
                        nxt.mday = cur.mday + 5'd1;
                    end
                end else begin
                    nxt.hour = cur.hour + 5'd1;
                end
            end else begin
                nxt.min = cur.min + 6'd1;
            end
        end else begin
            nxt.sec = cur.sec + 6'd1;
        end
    end
endmodule

// File: rtl/calword_alarm.sv
module calword_alarm
    import calword_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cal_time_t         cur,
    input  logic [YEAR_W-1:0] cur_year,
    input  cal_time_t         want,
    input  logic [YEAR_W-1:0] want_year,
    input  logic              clr,
    output logic              flag
);
    logic hit, hit_q;

    assign hit = (cur == want) && (cur_year == want_year);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            flag  <= 1'b0;
        end else begin
            hit_q <= hit;
            if (clr)
                flag <= 1'b0;
            else if (hit && !hit_q)
                flag <= 1'b1;
        end
    end

    a_r9_rise_needs_match: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(cur == want && cur_year == want_year));
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag);
    a_r10_no_year_no_flag: assert property (@(posedge clk) disable iff (rst)
        (cur_year != want_year && !flag && !clr) |=> !flag);
endmodule

// File: rtl/calword_top.sv
module calword_top
    import calword_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sec_tick,
    input  logic [31:0] wr_data,
    input  logic        year_we,
    input  logic        time_we,
    input  logic        match_year_we,
    input  logic        match_time_we,
    input  logic        alarm_clr,
    output logic [31:0] now_time,
    output logic [15:0] now_year,
    output logic        alarm
);
    cal_time_t         cur_t, nxt_t, match_t, wr_t;
    logic [YEAR_W-1:0] cur_y, nxt_y, match_y, year_stage, match_stage;

    always_comb begin
        wr_t     = cal_time_t'(wr_data);
        wr_t.pad = '0;
    end

    calword_step u_step (
        .cur      (cur_t),
        .cur_year (cur_y),
        .nxt      (nxt_t),
        .nxt_year (nxt_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_t       <= TIME_AT_RESET;
            cur_y       <= YEAR_AT_RESET;
            year_stage  <= YEAR_AT_RESET;
            match_t     <= '0;
            match_y     <= '0;
            match_stage <= '0;
        end else begin
            if (year_we)
                year_stage <= wr_data[YEAR_W-1:0];
            if (match_year_we)
                match_stage <= wr_data[YEAR_W-1:0];
            if (match_time_we) begin
                match_t <= wr_t;
                match_y <= match_stage;
            end
            if (time_we) begin
                cur_t <= wr_t;
                cur_y <= year_stage;
            end else if (sec_tick) begin
                cur_t <= nxt_t;
                cur_y <= nxt_y;
            end
        end
    end

    calword_alarm u_alarm (
        .clk       (clk),
        .rst       (rst),
        .cur       (cur_t),
        .cur_year  (cur_y),
        .want      (match_t),
        .want_year (match_y),
        .clr       (alarm_clr),
        .flag      (alarm)
    );

    assign now_time = cur_t;
    assign now_year = cur_y;

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !time_we) |=> ($stable(cur_t) && $stable(cur_y)));
    a_r4_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !time_we && cur_t.sec == 6'd59) |=> (cur_t.sec == 6'd0));
    a_r7_year_only_new_year: assert property (@(posedge clk) disable iff (rst)
        !time_we |=> ($stable(cur_y) || (cur_t.mon == 4'd1 && cur_t.mday == 5'd1)));
    a_r8_commit_staged_year: assert property (@(posedge clk) disable iff (rst)
        time_we |=> (cur_y == $past(year_stage)));
    a_r2_pad_zero: assert property (@(posedge clk) disable iff (rst)
        now_time[31:29] == 3'd0);
endmodule

// File: tb/calword_top_tb.sv
module calword_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic [31:0] wr_data = '0;
    logic        year_we = 1'b0, time_we = 1'b0;
    logic        match_year_we = 1'b0, match_time_we = 1'b0;
    logic        alarm_clr = 1'b0;
    logic [31:0] now_time;
    logic [15:0] now_year;
    logic        alarm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference calendar state
    int m_s, m_mi, m_h, m_wd, m_md, m_mo, m_y;

    always #5 clk = ~clk;

    calword_top u_dut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_data(wr_data),
        .year_we(year_we), .time_we(time_we),
        .match_year_we(match_year_we), .match_time_we(match_time_we),
        .alarm_clr(alarm_clr), .now_time(now_time), .now_year(now_year),
        .alarm(alarm)
    );

    function automatic logic [31:0] pack(int s, int mi, int h, int wd, int md, int mo);
        return (32'(mo) << 25) | (32'(md) << 20) | (32'(wd) << 17) |
               (32'(h) << 12) | (32'(mi) << 6) | 32'(s);
    endfunction

    function automatic logic [15:0] bcd4(int y);
        return {4'((y / 1000) % 10), 4'((y / 100) % 10), 4'((y / 10) % 10), 4'(y % 10)};
    endfunction

    function automatic int dim(int mo, int y);
        bit lp;
        lp = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_clock(string req);
        chk(req, {now_year, 16'h0} | 32'(0), {bcd4(m_y), 16'h0});
        chk(req, now_time, pack(m_s, m_mi, m_h, m_wd, m_md, m_mo));
    endtask

    task automatic set_model(int s, int mi, int h, int wd, int md, int mo, int y);
        m_s = s; m_mi = mi; m_h = h; m_wd = wd; m_md = md; m_mo = mo; m_y = y;
    endtask

    task automatic load_clock(int s, int mi, int h, int wd, int md, int mo, int y);
        year_we = 1'b1; wr_data = 32'(bcd4(y));
        step();
        year_we = 1'b0; time_we = 1'b1; wr_data = pack(s, mi, h, wd, md, mo);
        step();
        time_we = 1'b0;
        set_model(s, mi, h, wd, md, mo, y);
    endtask

    task automatic model_tick();
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_mi++;
            if (m_mi == 60) begin
                m_mi = 0; m_h++;
                if (m_h == 24) begin
                    m_h = 0;
                    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
                    if (m_md == dim(m_mo, m_y)) begin
                        m_md = 1;
                        if (m_mo == 12) begin m_mo = 1; m_y++; end
                        else m_mo++;
                    end else m_md++;
                end
            end
        end
    endtask

    task automatic tick_and_check(string req);
        sec_tick = 1'b1;
        step();
        sec_tick = 1'b0;
        model_tick();
        chk_clock(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) step();
        rst = 1'b0;
        // R1 reset values
        chk("R1 time", now_time, 32'h021E0000);
        chk("R1 year", {16'h0, now_year}, 32'h00002000);
        chk("R1 alarm", {31'h0, alarm}, 32'h0);

        // R3 hold without tick
        repeat (5) step();
        chk("R3 time", now_time, 32'h021E0000);
        chk("R3 year", {16'h0, now_year}, 32'h00002000);

        // R2 pad bits forced to zero on load
        time_we = 1'b1; wr_data = 32'hE0000000 | pack(12, 34, 5, 3, 17, 6);
        step();
        time_we = 1'b0;
        chk("R2 packing", now_time, pack(12, 34, 5, 3, 17, 6));

        // R8 year write alone is not visible
        year_we = 1'b1; wr_data = 32'h00001987;
        step();
        year_we = 1'b0;
        chk("R8 staged year hidden", {16'h0, now_year}, 32'h00002000);
        // R8 time write beats tick and commits staged year
        time_we = 1'b1; sec_tick = 1'b1; wr_data = pack(0, 0, 1, 2, 3, 4);
        step();
        time_we = 1'b0; sec_tick = 1'b0;
        chk("R8 load over tick", now_time, pack(0, 0, 1, 2, 3, 4));
        chk("R8 year committed", {16'h0, now_year}, 32'h00001987);

        // R4 field wraps
        load_clock(59, 59, 22, 4, 10, 7, 2013);
        tick_and_check("R4 hour carry");
        load_clock(58, 59, 23, 2, 5, 5, 2013);
        tick_and_check("R4 sec");
        tick_and_check("R4 midnight");
        // R5 weekday wrap
        load_clock(59, 59, 23, 7, 9, 9, 2021);
        tick_and_check("R5 weekday 7 to 1");
        // R6 month lengths
        load_clock(59, 59, 23, 1, 28, 2, 2000);
        tick_and_check("R6 leap 2000 feb 29");
        load_clock(59, 59, 23, 1, 28, 2, 2100);
        tick_and_check("R6 2100 not leap");
        load_clock(59, 59, 23, 1, 29, 2, 2024);
        tick_and_check("R6 2024 feb end");
        load_clock(59, 59, 23, 1, 28, 2, 2023);
        tick_and_check("R6 2023 feb end");
        load_clock(59, 59, 23, 1, 30, 4, 2023);
        tick_and_check("R6 april end");
        load_clock(59, 59, 23, 1, 30, 1, 2023);
        tick_and_check("R6 jan 30 continues");
        // R7 year carry
        load_clock(59, 59, 23, 5, 31, 12, 1999);
        tick_and_check("R7 1999 to 2000");
        load_clock(59, 59, 23, 5, 31, 12, 2099);
        tick_and_check("R7 2099 to 2100");
        load_clock(59, 59, 23, 5, 31, 12, 2009);
        tick_and_check("R7 2009 to 2010");

        // random dates biased toward field ends (R4 R5 R6 R7)
        for (int n = 0; n < 300; n++) begin
            int y, mo, md, h, mi, s, wd, k;
            y  = 1900 + int'($urandom % 500);
            mo = 1 + int'($urandom % 12);
            md = ($urandom % 3 == 0) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y));
            h  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
            mi = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            s  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            wd = 1 + int'($urandom % 7);
            if ($urandom % 4 == 0) begin mo = 12; md = 31; h = 23; mi = 59; s = 59; end
            load_clock(s, mi, h, wd, md, mo, y);
            k = 1 + int'($urandom % 3);
            for (int j = 0; j < k; j++) tick_and_check("R4 R5 R6 R7 random");
        end

        // R9 alarm
        match_year_we = 1'b1; wr_data = 32'h00002001;
        step();
        match_year_we = 1'b0; match_time_we = 1'b1; wr_data = pack(0, 0, 8, 3, 2, 1);
        step();
        match_time_we = 1'b0;
        chk("R9 no alarm yet", {31'h0, alarm}, 32'h0);
        load_clock(59, 59, 7, 3, 2, 1, 2001);
        sec_tick = 1'b1;
        step();
        sec_tick = 1'b0;
        chk("R9 time reached", now_time, pack(0, 0, 8, 3, 2, 1));
        chk("R9 flag one cycle later, still 0", {31'h0, alarm}, 32'h0);
        step();
        chk("R9 flag set", {31'h0, alarm}, 32'h1);
        repeat (3) step();
        chk("R9 sticky", {31'h0, alarm}, 32'h1);
        alarm_clr = 1'b1;
        step();
        alarm_clr = 1'b0;
        chk("R9 cleared", {31'h0, alarm}, 32'h0);
        step();
        chk("R9 stays clear while equal", {31'h0, alarm}, 32'h0);

        // R10 year mismatch
        load_clock(59, 59, 7, 3, 2, 1, 2002);
        sec_tick = 1'b1;
        step();
        sec_tick = 1'b0;
        step();
        step();
        chk("R10 year differs", {31'h0, alarm}, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule